// File: doc/BRIEF.md
# Programmable Counter/Timer with Receive Timeout

This block is a 16-bit programmable divider built around one shared down-counter. It has three operating modes:

- **Timer mode** is free running. It produces a symmetric square wave with a half period of N source ticks.
- **Counter mode** is a one-shot down count. It flags when the count steps down to zero.
- **Timeout mode** watches the gap between received characters. Each character strobe restarts the count, and the block flags when the line has stayed quiet for N ticks.

The divisor N is assembled from two byte-wide preload registers. A divisor of zero behaves as 65536.

The counter advances only on an enable pulse from one of four clock sources, chosen by a 2-bit field:

| Field value | Source |
|---|---|
| 0 | External pin |
| 1 | Transmitter A 1X clock |
| 2 | Transmitter B 1X clock |
| 3 | Crystal |

Start and stop arrive as single-cycle command strobes, decoded elsewhere from register reads. A ready status bit records the completion events. An interrupt request pulses for one cycle whenever ready is set. The live count is brought out so that it can be read back.

Top module: `ctmr_top`

## Requirements
- R1: The divisor is {hi byte, lo byte}. A divisor of 0 counts 65536 ticks: after start, the first tick takes the count to 0xFFFF, and ready is set on the 65536th tick.
- R2: In timer mode (`mode_sel[2]`=1, `tmo_en`=0), start sets `sq_out` high. `sq_out` then toggles after every N ticks. Outside timer mode `sq_out` never changes except through start.
- R3: In timer mode, ready is set when `sq_out` goes from 1 to 0, and never on the 0-to-1 edge. Every setting of ready comes with a one-cycle `irq` pulse in the same cycle.
- R4: A start strobe copies the current preload value into the count one cycle later and starts counting. A tick in the same cycle does not change the loaded value.
- R5: A stop strobe clears ready in the next cycle. In timer mode it does not halt the counter.
- R6: In counter mode (`mode_sel[2]`=0, `tmo_en`=0), ready is set on the tick that takes the count from 1 to 0. A stop strobe freezes the count from that cycle until the next start.
- R7: A preload write in timer mode does not change the half period in progress. The new divisor is used from the next reload on.
- R8: In timeout mode (`tmo_en`=1), each `rx_char` strobe reloads the count and restarts it. Ready is not cleared by `rx_char`. When the count expires, ready is set and the count halts at 0 until the next `rx_char` or start.
- R9: Only the enable pulse selected by `mode_sel[1:0]` advances the count (0 external, 1 transmitter A, 2 transmitter B, 3 crystal). Pulses on the other three sources have no effect.
- R10: After reset: count 0, ready 0, `irq` 0, `sq_out` 1, and the counter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pl_wr | input | 1 | Preload byte write strobe |
| pl_wr_hi | input | 1 | Byte select for the write: 1 upper, 0 lower |
| pl_data | input | 8 | Preload byte value |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| mode_sel | input | 3 | Bit 2: timer (1) or counter (0). Bits 1:0: clock source |
| tmo_en | input | 1 | Timeout mode enable; overrides `mode_sel[2]` |
| src_ext | input | 1 | External-pin tick enable |
| src_txa | input | 1 | Transmitter A 1X tick enable |
| src_txb | input | 1 | Transmitter B 1X tick enable |
| src_xtal | input | 1 | Crystal tick enable |
| rx_char | input | 1 | Strobe: a received character entered the receive FIFO |
| ready | output | 1 | Ready status bit |
| irq | output | 1 | One-cycle pulse whenever ready is set |
| sq_out | output | 1 | Square-wave output |
| count | output | 16 | Current counting-register value |

## Verification
The assertions take for granted that start and stop are never strobed in the same cycle. They also take for granted that mode and select inputs change only while no command is in flight, because the stop and hold properties read the mode of the cycle being checked. The directed tasks issue every command in a cycle of its own and set up the mode before loading. They never strobe stop in the cycle in which the count expires, so each ready check follows from a single event.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

    typedef enum logic [1:0] {
        CM_COUNT = 2'd0,
        CM_TIMER = 2'd1,
        CM_TMO   = 2'd2
    } ctmr_mode_e;

endpackage

// File: rtl/ctmr_src_mux.sv
module ctmr_src_mux #(
    parameter  int NSRC  = 4,
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]  src_en,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // One enable pulse per source; only the selected one advances the counter.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) begin
                tick = src_en[i];
            end
        end
    end

endmodule

// File: rtl/ctmr_preload.sv
module ctmr_preload #(
    parameter  int BYTE_W = 8,
    parameter  int NBYTE  = 2,
    localparam int IDX_W  = (NBYTE > 1) ? $clog2(NBYTE) : 1,
    localparam int PL_W   = BYTE_W * NBYTE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [PL_W-1:0]   preload
);

    logic [NBYTE-1:0][BYTE_W-1:0] pl_d, pl_q;

    always_comb begin
        pl_d = pl_q;
        for (int b = 0; b < NBYTE; b++) begin
            if (wr_en && (wr_idx == IDX_W'(b))) begin
                pl_d[b] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q <= '0;
        end else begin
            pl_q <= pl_d;
        end
    end

    assign preload = pl_q;

endmodule

// File: rtl/ctmr_core.sv
module ctmr_core
    import ctmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctmr_mode_e       mode,
    input  logic             tick,
    input  logic             start,
    input  logic             stop,
    input  logic             rx_char,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             sq,
    output logic             ready,
    output logic             irq
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             sq;
        logic             ready;
        logic             irq;
    } core_st_t;

    localparam core_st_t ST_RST = '{cnt: '0, run: 1'b0, sq: 1'b1, ready: 1'b0, irq: 1'b0};

    core_st_t s_d, s_q;
    logic     load_w, halt_w, expire_w, set_w;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        set_w    = 1'b0;
        load_w   = start | ((mode == CM_TMO) & rx_char);
        halt_w   = stop & (mode != CM_TIMER);
        expire_w = s_q.run & tick & (s_q.cnt == CNT_W'(1));

        if (load_w) begin
            // A zero preload is not special: the next decrement wraps to all ones.
            s_d.cnt = preload;
            s_d.run = 1'b1;
            if (start) begin
                s_d.sq = 1'b1;
            end
        end else if (halt_w) begin
            s_d.run = 1'b0;
        end else if (s_q.run & tick) begin
            if (expire_w) begin
                if (mode == CM_TIMER) begin
                    // End of a half period: reload with the divisor now held.
                    s_d.cnt = preload;
                    s_d.sq  = ~s_q.sq;
                    set_w   = s_q.sq;
                end else begin
                    s_d.cnt = '0;
                    set_w   = 1'b1;
                    if (mode == CM_TMO) begin
                        s_d.run = 1'b0;
                    end
                end
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        if (stop) begin
            s_d.ready = 1'b0;
        end
        // Setting ready takes precedence over a stop in the same cycle.
        if (set_w) begin
            s_d.ready = 1'b1;
            s_d.irq   = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= ST_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;
    assign sq    = s_q.sq;
    assign ready = s_q.ready;
    assign irq   = s_q.irq;

endmodule

// File: rtl/ctmr_top.sv
module ctmr_top
    import ctmr_pkg::*;
#(
    parameter  int BYTE_W = 8,
    parameter  int NSRC   = 4,
    localparam int CNT_W  = 2 * BYTE_W,
    localparam int SEL_W  = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pl_wr,
    input  logic              pl_wr_hi,
    input  logic [BYTE_W-1:0] pl_data,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic [SEL_W:0]    mode_sel,
    input  logic              tmo_en,
    input  logic              src_ext,
    input  logic              src_txa,
    input  logic              src_txb,
    input  logic              src_xtal,
    input  logic              rx_char,
    output logic              ready,
    output logic              irq,
    output logic              sq_out,
    output logic [CNT_W-1:0]  count
);

    logic [CNT_W-1:0] preload_w;
    logic             tick_w;
    ctmr_mode_e       mode_w;

    always_comb begin
        if (tmo_en) begin
            mode_w = CM_TMO;
        end else if (mode_sel[SEL_W]) begin
            mode_w = CM_TIMER;
        end else begin
            mode_w = CM_COUNT;
        end
    end

    ctmr_preload #(.BYTE_W(BYTE_W), .NBYTE(2)) u_preload (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pl_wr),
        .wr_idx  (pl_wr_hi),
        .wr_data (pl_data),
        .preload (preload_w)
    );

    ctmr_src_mux #(.NSRC(NSRC)) u_src (
        .src_en ({src_xtal, src_txb, src_txa, src_ext}),
        .sel    (mode_sel[SEL_W-1:0]),
        .tick   (tick_w)
    );

    ctmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_w),
        .tick    (tick_w),
        .start   (cmd_start),
        .stop    (cmd_stop),
        .rx_char (rx_char),
        .preload (preload_w),
        .count   (count),
        .sq      (sq_out),
        .ready   (ready),
        .irq     (irq)
    );

endmodule

// File: rtl/ctmr_checker.sv
module ctmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_start,
    input logic             cmd_stop,
    input logic [2:0]       mode_sel,
    input logic             tmo_en,
    input logic             rx_char,
    input logic             ready,
    input logic             irq,
    input logic             sq_out,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] preload_w
);

    logic timer_mode;
    assign timer_mode = mode_sel[2] && !tmo_en;

    // Input assumption: start and stop never arrive in the same cycle.
    p_cmd_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_start && cmd_stop));

    p_start_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> count == $past(preload_w));

    p_stop_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stop && !cmd_start |=> !ready || irq);

    p_irq_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready);

    p_rise_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> irq);

    p_ready_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) && $past(timer_mode) |-> $fell(sq_out));

    p_sq_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_mode && !cmd_start |=> sq_out == $past(sq_out));

    p_stop_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !timer_mode && cmd_stop && !cmd_start |=> count == $past(count));

    p_tmo_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_en && irq && !cmd_start && !rx_char |=> count == '0);

endmodule

bind ctmr_top ctmr_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/ctmr_top_tb.sv
module ctmr_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pl_wr = 1'b0, pl_wr_hi = 1'b0;
    logic [7:0]  pl_data = '0;
    logic        cmd_start = 1'b0, cmd_stop = 1'b0;
    logic [2:0]  mode_sel = '0;
    logic        tmo_en = 1'b0;
    logic        src_ext = 1'b0, src_txa = 1'b0, src_txb = 1'b0, src_xtal = 1'b0;
    logic        rx_char = 1'b0;
    logic        ready, irq, sq_out;
    logic [15:0] count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ctmr_top u_dut (
        .clk(clk), .rst_n(rst_n), .pl_wr(pl_wr), .pl_wr_hi(pl_wr_hi), .pl_data(pl_data),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .mode_sel(mode_sel), .tmo_en(tmo_en),
        .src_ext(src_ext), .src_txa(src_txa), .src_txb(src_txb), .src_xtal(src_xtal),
        .rx_char(rx_char), .ready(ready), .irq(irq), .sq_out(sq_out), .count(count)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr_pl(input logic hi, input logic [7:0] v);
        pl_wr = 1'b1; pl_wr_hi = hi; pl_data = v;
        step(1);
        pl_wr = 1'b0;
    endtask

    task automatic do_start();
        cmd_start = 1'b1; step(1); cmd_start = 1'b0;
    endtask

    task automatic do_stop();
        cmd_stop = 1'b1; step(1); cmd_stop = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10", "count", count, 0);
        chk("R10", "ready", ready, 0);
        chk("R10", "irq", irq, 0);
        chk("R10", "sq_out", sq_out, 1);
    endtask

    task automatic t_timer();
        mode_sel = 3'b111; tmo_en = 1'b0;
        wr_pl(1'b0, 8'd4); wr_pl(1'b1, 8'd0);
        do_start();
        chk("R4", "timer load", count, 4);
        chk("R2", "sq after start", sq_out, 1);
        src_xtal = 1'b1;
        step(3);
        chk("R2", "sq before half", sq_out, 1);
        chk("R3", "ready before fall", ready, 0);
        step(1);
        chk("R2", "sq at half", sq_out, 0);
        chk("R3", "ready on fall", ready, 1);
        chk("R3", "irq on fall", irq, 1);
        do_stop();
        chk("R5", "ready after stop", ready, 0);
        chk("R5", "timer keeps counting", count, 3);
        step(3);
        chk("R2", "sq rise", sq_out, 1);
        chk("R3", "no ready on rise", ready, 0);
        step(3);
        pl_wr = 1'b1; pl_wr_hi = 1'b0; pl_data = 8'd2;
        step(1);
        pl_wr = 1'b0;
        chk("R3", "ready second fall", ready, 1);
        chk("R7", "reload uses old value", count, 4);
        step(3);
        chk("R7", "old half period kept", sq_out, 0);
        step(1);
        chk("R7", "rise after old half", sq_out, 1);
        chk("R7", "new divisor loaded", count, 2);
        step(2);
        chk("R7", "new half period", sq_out, 0);
        src_xtal = 1'b0;
        do_stop();
    endtask

    task automatic t_counter_src();
        mode_sel = 3'b001; tmo_en = 1'b0;
        wr_pl(1'b0, 8'd5); wr_pl(1'b1, 8'd0);
        do_start();
        chk("R4", "counter load", count, 5);
        src_ext = 1'b1; src_txb = 1'b1; src_xtal = 1'b1;
        step(6);
        src_ext = 1'b0; src_txb = 1'b0; src_xtal = 1'b0;
        chk("R9", "unselected sources ignored", count, 5);
        chk("R9", "ready untouched", ready, 0);
        src_txa = 1'b1;
        step(4);
        chk("R6", "count before terminal", count, 1);
        chk("R6", "ready before terminal", ready, 0);
        step(1);
        src_txa = 1'b0;
        chk("R6", "count at terminal", count, 0);
        chk("R6", "ready at terminal", ready, 1);
        chk("R3", "irq at terminal", irq, 1);
        step(1);
        chk("R3", "irq one cycle", irq, 0);
        chk("R6", "ready held", ready, 1);
        src_txa = 1'b1;
        do_stop();
        chk("R5", "stop clears ready", ready, 0);
        chk("R6", "stop freezes", count, 0);
        step(4);
        src_txa = 1'b0;
        chk("R6", "stays halted", count, 0);
        wr_pl(1'b1, 8'h12); wr_pl(1'b0, 8'h34);
        mode_sel = 3'b000;
        do_start();
        chk("R1", "two byte divisor", count, 16'h1234);
        src_ext = 1'b1; step(1); src_ext = 1'b0;
        chk("R9", "external source", count, 16'h1233);
        do_stop();
    endtask

    task automatic t_zero();
        mode_sel = 3'b011; tmo_en = 1'b0;
        wr_pl(1'b0, 8'd0); wr_pl(1'b1, 8'd0);
        do_start();
        chk("R1", "zero loaded", count, 0);
        src_xtal = 1'b1;
        step(1);
        chk("R1", "zero wraps", count, 16'hFFFF);
        step(65534);
        chk("R1", "one tick left", count, 1);
        chk("R1", "no ready yet", ready, 0);
        step(1);
        chk("R1", "ready after 65536", ready, 1);
        src_xtal = 1'b0;
        do_stop();
    endtask

    task automatic t_timeout();
        tmo_en = 1'b1; mode_sel = 3'b011;
        wr_pl(1'b0, 8'd6); wr_pl(1'b1, 8'd0);
        src_xtal = 1'b1;
        rx_char = 1'b1; step(1); rx_char = 1'b0;
        chk("R8", "char loads", count, 6);
        step(4);
        chk("R8", "counting down", count, 2);
        rx_char = 1'b1; step(1); rx_char = 1'b0;
        chk("R8", "char restarts", count, 6);
        chk("R8", "no ready yet", ready, 0);
        step(5);
        chk("R8", "before expiry", count, 1);
        step(1);
        chk("R8", "ready on expiry", ready, 1);
        step(3);
        chk("R8", "halted after expiry", count, 0);
        rx_char = 1'b1; step(1); rx_char = 1'b0;
        chk("R8", "char after expiry", count, 6);
        chk("R8", "ready kept by char", ready, 1);
        do_stop();
        chk("R5", "stop clears ready", ready, 0);
        step(3);
        chk("R6", "stop halts timeout", count, 6);
        src_xtal = 1'b0; tmo_en = 1'b0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_timer();
        t_counter_src();
        t_zero();
        t_timeout();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule